// File: doc/BRIEF.md
# Latched Multiplexing Bus Transceiver

This block joins two 16-bit data paths, port A and port B, to one shared port AB, and sends AB traffic back out to A or to B. Each direction has its own level-sensitive storage latch. There are four of them: an A-side capture latch, a B-side capture latch, and two independent AB-side capture latches. One of those feeds the A outputs and the other feeds the B outputs. A select input picks which of the A or B latched words appears on AB. A bus controller can therefore hold an address on one path while data moves on the other, or keep two different AB words for two memory banks.

Every latch control is active low. While it is low the latch is transparent. On its rising edge the latch keeps the word then present, until the control returns low. Each port has two active-low byte enables: one for the upper byte and one for the lower byte. A build parameter chooses whether every path between A/B and AB passes data unchanged or inverts it bit by bit. In the core, each bidirectional port is split into an input vector, an output vector and per-byte output-enable bits, so a surrounding pad ring can build the tri-state drivers.

Top module: `mux_bus_xcvr`

## Requirements
- R1: While `rst_n` is low, all four latches hold zero. Every enabled output byte then shows the path polarity applied to zero: zero when non-inverting, all ones when inverting.
- R2: While a latch control (`a_lat_n`, `b_lat_n`, `ab2a_lat_n`, `ab2b_lat_n`) is low, the output it feeds follows its input word in the same cycle.
- R3: After a latch control rises, the output it feeds keeps the word captured at that edge, whatever the input later does, until the control goes low again.
- R4: `sel_b` = 0 puts the A-path latch on `ab_out`, and `sel_b` = 1 puts the B-path latch there. Switching `sel_b` alone moves between the two held words.
- R5: The AB-to-A latch and the AB-to-B latch are independent, so `a_out` and `b_out` can hold two different AB words at the same time.
- R6: Bit 0 of each `*_en_n` and `*_oe` pair belongs to bits 7..0, and bit 1 belongs to bits 15..8. An enable input that is high makes the matching `*_oe` bit 0 and forces that output byte to zero. An enable input that is low sets `*_oe` to 1 and shows the data. The two bytes of each port act independently.
- R7: With `INVERT` = 1, every A/B-to-AB and AB-to-A/B path gives the bitwise complement of its latched word. With `INVERT` = 0, the word passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset that clears all four latches |
| a_in | input | 16 | Word received on port A |
| a_lat_n | input | 1 | Active-low latch control of the A capture latch |
| b_in | input | 16 | Word received on port B |
| b_lat_n | input | 1 | Active-low latch control of the B capture latch |
| ab_in | input | 16 | Word received on the shared port |
| ab2a_lat_n | input | 1 | Active-low latch control of the AB-to-A latch |
| ab2b_lat_n | input | 1 | Active-low latch control of the AB-to-B latch |
| sel_b | input | 1 | Shared port source: 0 = A path, 1 = B path |
| a_en_n | input | 2 | Active-low byte enables of port A (bit 1 = upper byte) |
| b_en_n | input | 2 | Active-low byte enables of port B |
| ab_en_n | input | 2 | Active-low byte enables of the shared port |
| a_out | output | 16 | Word driven on port A, zero in disabled bytes |
| a_oe | output | 2 | Per-byte drive enable of port A |
| b_out | output | 16 | Word driven on port B, zero in disabled bytes |
| b_oe | output | 2 | Per-byte drive enable of port B |
| ab_out | output | 16 | Word driven on the shared port, zero in disabled bytes |
| ab_oe | output | 2 | Per-byte drive enable of the shared port |

## Verification
The bench drives a non-inverting and an inverting copy from the same stimulus. Sweeping computed words through each transparent path exposes a stuck or swapped bit and a missing complement. Changing inputs after a latch control rises separates a real hold from a transparent one. Loading different words into the two AB-side latches, and toggling `sel_b` over two held words, shows whether the select or the AB-side storage has its sides crossed. All four byte-enable combinations on each port catch byte lanes that are swapped or tied together.

// File: rtl/mux_xcvr_pkg.sv
package mux_xcvr_pkg;
   typedef enum logic {
      SRC_A = 1'b0,
      SRC_B = 1'b1
   } src_sel_e;
endpackage

// File: rtl/xcvr_latch.sv
module xcvr_latch #(
   parameter int W = 16
) (
   input  logic         rst_n,
   input  logic         le_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("xcvr_latch: W must be positive");
   end

   always_latch begin
      if (!rst_n)     q = '0;
      else if (!le_n) q = d;
   end
endmodule

// File: rtl/xcvr_port_drive.sv
module xcvr_port_drive #(
   parameter int W      = 16,
   parameter int BYTE_W = 8,
   parameter bit INVERT = 1'b0,
   localparam int NB    = W / BYTE_W
) (
   input  logic [W-1:0]  d,
   input  logic [NB-1:0] en_n,
   output logic [W-1:0]  out,
   output logic [NB-1:0] oe
);
   logic [W-1:0] pol;

   if (W % BYTE_W != 0) begin : g_bad_split
      $error("xcvr_port_drive: W must be a multiple of BYTE_W");
   end

   if (INVERT) begin : g_inv
      assign pol = ~d;
   end else begin : g_pass
      assign pol = d;
   end

   for (genvar k = 0; k < NB; k++) begin : g_byte
      assign oe[k] = ~en_n[k];
      assign out[k*BYTE_W +: BYTE_W] = en_n[k] ? '0 : pol[k*BYTE_W +: BYTE_W];
   end
endmodule

// File: rtl/mux_bus_xcvr.sv
module mux_bus_xcvr
   import mux_xcvr_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter int BYTE_W = 8,
   parameter bit INVERT = 1'b0,
   localparam int NB    = WIDTH / BYTE_W
) (
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic             a_lat_n,
   input  logic [WIDTH-1:0] b_in,
   input  logic             b_lat_n,
   input  logic [WIDTH-1:0] ab_in,
   input  logic             ab2a_lat_n,
   input  logic             ab2b_lat_n,
   input  logic             sel_b,
   input  logic [NB-1:0]    a_en_n,
   input  logic [NB-1:0]    b_en_n,
   input  logic [NB-1:0]    ab_en_n,
   output logic [WIDTH-1:0] a_out,
   output logic [NB-1:0]    a_oe,
   output logic [WIDTH-1:0] b_out,
   output logic [NB-1:0]    b_oe,
   output logic [WIDTH-1:0] ab_out,
   output logic [NB-1:0]    ab_oe
);
   if (WIDTH % BYTE_W != 0 || NB < 1) begin : g_bad_cfg
      $error("mux_bus_xcvr: WIDTH must be a positive multiple of BYTE_W");
   end

   logic [WIDTH-1:0] a_q, b_q, ab2a_q, ab2b_q, ab_src;

   // Four independent storage latches
   xcvr_latch #(.W(WIDTH)) u_lat_a    (.rst_n(rst_n), .le_n(a_lat_n),    .d(a_in),  .q(a_q));
   xcvr_latch #(.W(WIDTH)) u_lat_b    (.rst_n(rst_n), .le_n(b_lat_n),    .d(b_in),  .q(b_q));
   xcvr_latch #(.W(WIDTH)) u_lat_ab2a (.rst_n(rst_n), .le_n(ab2a_lat_n), .d(ab_in), .q(ab2a_q));
   xcvr_latch #(.W(WIDTH)) u_lat_ab2b (.rst_n(rst_n), .le_n(ab2b_lat_n), .d(ab_in), .q(ab2b_q));

   // Source select onto the shared port
   always_comb begin
      unique case (src_sel_e'(sel_b))
         SRC_B:   ab_src = b_q;
         default: ab_src = a_q;
      endcase
   end

   xcvr_port_drive #(.W(WIDTH), .BYTE_W(BYTE_W), .INVERT(INVERT)) u_drv_ab
      (.d(ab_src), .en_n(ab_en_n), .out(ab_out), .oe(ab_oe));
   xcvr_port_drive #(.W(WIDTH), .BYTE_W(BYTE_W), .INVERT(INVERT)) u_drv_a
      (.d(ab2a_q), .en_n(a_en_n), .out(a_out), .oe(a_oe));
   xcvr_port_drive #(.W(WIDTH), .BYTE_W(BYTE_W), .INVERT(INVERT)) u_drv_b
      (.d(ab2b_q), .en_n(b_en_n), .out(b_out), .oe(b_oe));

   // End-to-end checks from input ports to output ports
   always_comb begin
      if (!rst_n && (&ab_oe)) begin
         a_r1_reset_ab : assert (ab_out == (INVERT ? ~WIDTH'(0) : WIDTH'(0)))
            else $error("R1: shared port not cleared in reset");
      end
      if (rst_n && !a_lat_n && !sel_b && (&ab_oe)) begin
         a_r2_a_transparent : assert (ab_out == (INVERT ? ~a_in : a_in))
            else $error("R2/R4: A path not transparent onto shared port");
      end
      if (rst_n && !b_lat_n && sel_b && (&ab_oe)) begin
         a_r4_b_selected : assert (ab_out == (INVERT ? ~b_in : b_in))
            else $error("R4: B path not selected onto shared port");
      end
      if (rst_n && !ab2a_lat_n && (&a_oe)) begin
         a_r7_ab2a_polarity : assert (a_out == (INVERT ? ~ab_in : ab_in))
            else $error("R7: AB to A path polarity wrong");
      end
      for (int k = 0; k < NB; k++) begin
         if (ab_en_n[k]) begin
            a_r6_ab_byte_off : assert (!ab_oe[k] && ab_out[k*BYTE_W +: BYTE_W] == '0)
               else $error("R6: disabled shared byte still driven");
         end
      end
   end
endmodule

// File: tb/mux_bus_xcvr_test.sv
module mux_bus_xcvr_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] a_in, b_in, ab_in;
   logic        a_lat_n, b_lat_n, ab2a_lat_n, ab2b_lat_n, sel_b;
   logic [1:0]  a_en_n, b_en_n, ab_en_n;

   logic [15:0] a_out0, b_out0, ab_out0, a_out1, b_out1, ab_out1;
   logic [1:0]  a_oe0, b_oe0, ab_oe0, a_oe1, b_oe1, ab_oe1;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mux_bus_xcvr #(.INVERT(1'b0)) uut (
      .rst_n, .a_in, .a_lat_n, .b_in, .b_lat_n, .ab_in, .ab2a_lat_n, .ab2b_lat_n,
      .sel_b, .a_en_n, .b_en_n, .ab_en_n,
      .a_out(a_out0), .a_oe(a_oe0), .b_out(b_out0), .b_oe(b_oe0),
      .ab_out(ab_out0), .ab_oe(ab_oe0));

   mux_bus_xcvr #(.INVERT(1'b1)) uut_inv (
      .rst_n, .a_in, .a_lat_n, .b_in, .b_lat_n, .ab_in, .ab2a_lat_n, .ab2b_lat_n,
      .sel_b, .a_en_n, .b_en_n, .ab_en_n,
      .a_out(a_out1), .a_oe(a_oe1), .b_out(b_out1), .b_oe(b_oe1),
      .ab_out(ab_out1), .ab_oe(ab_oe1));

   function automatic logic [15:0] expv(input logic [15:0] x, input bit inv,
                                        input logic [1:0] en_n);
      logic [15:0] v;
      v = inv ? ~x : x;
      if (en_n[0]) v[7:0]  = 8'h00;
      if (en_n[1]) v[15:8] = 8'h00;
      return v;
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Check all three data ports of both builds against stored words
   task automatic chk_all(input string tag, input logic [15:0] ab_w,
                          input logic [15:0] a_w, input logic [15:0] b_w);
      chk({tag, " ab pass"}, ab_out0, expv(ab_w, 1'b0, ab_en_n));
      chk({tag, " ab inv"},  ab_out1, expv(ab_w, 1'b1, ab_en_n));
      chk({tag, " a pass"},  a_out0,  expv(a_w,  1'b0, a_en_n));
      chk({tag, " a inv"},   a_out1,  expv(a_w,  1'b1, a_en_n));
      chk({tag, " b pass"},  b_out0,  expv(b_w,  1'b0, b_en_n));
      chk({tag, " b inv"},   b_out1,  expv(b_w,  1'b1, b_en_n));
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [15:0] held_a, held_b, w1, w2;
      // R1: reset clears latches even while transparent
      rst_n = 1'b0; a_lat_n = 1'b0; b_lat_n = 1'b0; ab2a_lat_n = 1'b0; ab2b_lat_n = 1'b0;
      sel_b = 1'b0; a_en_n = 2'b00; b_en_n = 2'b00; ab_en_n = 2'b00;
      a_in = 16'h1234; b_in = 16'h5678; ab_in = 16'h9ABC;
      settle();
      chk_all("R1 reset", 16'h0000, 16'h0000, 16'h0000);
      @(posedge clk); rst_n = 1'b1;
      settle();

      // R2/R4/R7: transparent A, B and AB paths over computed words
      for (int i = 0; i < 16; i++) begin
         @(posedge clk);
         a_in  = 16'(i * 16'h1111) ^ 16'hA5C3;
         b_in  = 16'(i * 16'h0F0F) ^ 16'h3C69;
         ab_in = 16'(i * 16'h2345) ^ 16'h8001;
         sel_b = i[0];
         settle();
         chk_all("R2 R4 R7 transparent", sel_b ? b_in : a_in, ab_in, ab_in);
      end

      // R3: hold A and B path words, then move inputs
      @(posedge clk);
      a_in = 16'hC0DE; b_in = 16'hBEEF; sel_b = 1'b0;
      @(posedge clk);
      a_lat_n = 1'b1; b_lat_n = 1'b1;
      held_a = 16'hC0DE; held_b = 16'hBEEF;
      @(posedge clk);
      a_in = 16'h0F0F; b_in = 16'hF0F0;
      settle();
      chk("R3 A hold pass", ab_out0, held_a);
      chk("R3 A hold inv",  ab_out1, ~held_a);
      // R4: select alone switches between held words
      @(posedge clk); sel_b = 1'b1;
      settle();
      chk("R4 sel B held pass", ab_out0, held_b);
      chk("R4 sel B held inv",  ab_out1, ~held_b);
      @(posedge clk); sel_b = 1'b0;
      settle();
      chk("R4 sel A held pass", ab_out0, held_a);

      // R5: two different AB words held for A and B
      @(posedge clk); ab_in = 16'h1357;
      @(posedge clk); ab2a_lat_n = 1'b1; w1 = 16'h1357;
      @(posedge clk); ab_in = 16'h2468;
      @(posedge clk); ab2b_lat_n = 1'b1; w2 = 16'h2468;
      @(posedge clk); ab_in = 16'hFFFF;
      settle();
      chk_all("R5 R3 independent AB latches", held_a, w1, w2);

      // R2: returning a control low makes the latch transparent again
      @(posedge clk); a_lat_n = 1'b0; ab2b_lat_n = 1'b0;
      settle();
      chk("R2 A reopen", ab_out0, a_in);
      chk("R2 AB2B reopen", b_out1, ~ab_in);
      chk("R5 AB2A still held", a_out0, w1);

      // R6: every byte-enable combination on every port
      for (int e = 0; e < 4; e++) begin
         @(posedge clk);
         a_en_n = e[1:0]; b_en_n = e[1:0] ^ 2'b11; ab_en_n = {e[0], e[1]};
         settle();
         chk_all("R6 byte enables", a_in, w1, ab_in);
         chk("R6 a_oe pass",  {14'd0, a_oe0},  {14'd0, ~a_en_n});
         chk("R6 b_oe inv",   {14'd0, b_oe1},  {14'd0, ~b_en_n});
         chk("R6 ab_oe pass", {14'd0, ab_oe0}, {14'd0, ~ab_en_n});
         chk("R6 ab_oe inv",  {14'd0, ab_oe1}, {14'd0, ~ab_en_n});
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule